// File: doc/BRIEF.md
# PCM Sample FIFO Status and Interrupt Unit

This unit sits between a host register port and the serial side of a PCM audio port. It holds one transmit FIFO and one receive FIFO of 16-bit sample words, each `DEPTH` entries deep. The host fills the transmit FIFO and drains the receive FIFO through a small register port. The serializer takes transmit words through a pop strobe, and the deserializer delivers receive words through a push strobe. The serial timing and the DMA engines themselves live outside this unit.

Each direction has a programmable 6-bit threshold. The threshold sets an almost-empty and an almost-full flag, and those flags in turn drive a per-direction DMA request. Every cycle the unit gathers thirteen event bits: the level flags of both FIFOs, overflow and starvation errors, and a word-transfer event. It records them as sticky status bits. Writing ones to a clear register removes status bits. An enable register masks the bits onto a single interrupt line, behind a global enable.

The word-address register map is: 0 control, 1 interrupt enable, 2 interrupt status (read), 3 status clear (write), 4 FIFO status (read), 5 transmit data (write), 6 receive data (read). Address 7 and the read of a write-only address return zero. `DEPTH` must not exceed 63 so that a count fits its 6-bit field.

Top module: `pcm_fifo_irq_unit`

## Requirements
- R1: After reset, both FIFOs are empty, the control and interrupt-enable registers read zero, and `irqOut`, `txDmaReq` and `rxDmaReq` are low.
- R2: A write to address 5 pushes `regWrData[15:0]` into the transmit FIFO only when `regWrData[16]` is 1. With bit 16 at 0 the FIFO count is unchanged.
- R3: Transmit words leave in write order on `txWord`. `txWordValid` is high exactly when the transmit FIFO is non-empty, and a `txPop` with valid high removes the head word.
- R4: Words pushed with `rxPush` are read back in order from address 6 as `{bit16 = 1, bits15:0 = word}`. A read while the receive FIFO is empty returns all zeros.
- R5: The FIFO status word (address 4) holds the TX count in bits 19:14 and the TX empty, almost-empty, full and almost-full flags in bits 13, 12, 11 and 10. It holds the RX count in bits 9:4 and the same four RX flags in bits 3, 2, 1 and 0.
- R6: The control word holds the TX threshold in bits 18:13, the RX threshold in bits 12:7, the TX DMA enable in bit 6 and the RX DMA enable in bit 5. It reads back as written, with the other bits zero. Almost-empty is count ≤ threshold, and almost-full is count + threshold ≥ DEPTH.
- R7: `txDmaReq` = TX DMA enable AND TX almost-empty AND NOT TX full. `rxDmaReq` = RX DMA enable AND RX almost-full AND NOT RX empty.
- R8: A valid transmit write to a full TX FIFO, or an `rxPush` into a full RX FIFO, drops the word and leaves the count at DEPTH. It sets status bit 6 (TX overflow) or status bit 0 (RX overflow).
- R9: A `txPop` while the TX FIFO is empty sets status bit 7 (TX starvation). A data read while the RX FIFO is empty sets status bit 1 (RX starvation).
- R10: The status bits are 0 RX overflow, 1 RX starve, 2 RX almost-full, 3 RX full, 4 RX almost-empty, 5 RX empty, 6 to 11 the same six TX events, and 12 word transfer. Each bit is sticky and is cleared by writing 1 to its position at address 3. An event present in the same cycle as the clear keeps the bit set.
- R11: `irqOut` is high when interrupt-enable bit 14 is set and at least one status bit is set whose enable bit (same position, bits 12:0) is set. Status bit 13 reads the same value.
- R12: A successful `txPop` or a successful `rxPush` sets status bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a read of address 6 pops the RX FIFO) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 19 | Register write data |
| regRdData | output | 20 | Register read data, combinational from `regAddr` |
| txPop | input | 1 | Serializer takes the TX head word |
| txWord | output | 16 | TX head word |
| txWordValid | output | 1 | TX FIFO non-empty |
| rxPush | input | 1 | Deserializer delivers a word |
| rxWord | input | 16 | Received word |
| txDmaReq | output | 1 | TX DMA request |
| rxDmaReq | output | 1 | RX DMA request |
| irqOut | output | 1 | Interrupt line |

## Verification
The bench builds the unit with DEPTH = 32, which is the largest power of two whose count, and whose threshold compare at the value 32, still fit the 6-bit fields. With this depth, both the overflow edge and the almost-full boundary at count + threshold = DEPTH are reached in a few hundred cycles. Thresholds of 4/32 and 3/2 are used, so almost-empty is tested exactly at count = threshold and almost-full at one word either side of the boundary. A threshold of 32 on receive makes the RX request follow non-emptiness alone.

// File: rtl/pcm_fifo_irq_pkg.sv
package pcm_fifo_irq_pkg;
  localparam int WORD_W  = 16;
  localparam int CNT_FW  = 6;   // count and threshold field width
  localparam int EVT_W   = 13;  // sticky status bits
  localparam int RD_W    = 20;
  localparam int WR_W    = 19;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_IRQEN  = 3'd1;
  localparam logic [2:0] ADDR_IRQST  = 3'd2;
  localparam logic [2:0] ADDR_IRQCLR = 3'd3;
  localparam logic [2:0] ADDR_FSTAT  = 3'd4;
  localparam logic [2:0] ADDR_TXDATA = 3'd5;
  localparam logic [2:0] ADDR_RXDATA = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic              txWrite;
    logic              rxRead;
    logic [WORD_W-1:0] txData;
  } dpStrobe_t;

  // per-direction FIFO state seen by control
  typedef struct packed {
    logic [CNT_FW-1:0] cnt;
    logic              empty;
    logic              almostEmpty;
    logic              full;
    logic              almostFull;
    logic              ovf;
    logic              starve;
    logic              xfer;
  } fifoState_t;
endpackage

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           push,
  input  logic [WIDTH-1:0]               pushData,
  input  logic                           pop,
  output logic [WIDTH-1:0]               headData,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             pushOk, popOk;

  assign pushOk   = push && (count != FULL_CNT);
  assign popOk    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (push && (count == FULL_CNT) && !pop) |=> (count == FULL_CNT)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (pop && (count == '0) && !push) |=> (count == '0)); // R9
endmodule

// File: rtl/pcm_fifo_dp.sv
module pcm_fifo_dp
  import pcm_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_FW-1:0] txThr,
  input  logic [CNT_FW-1:0] rxThr,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxHead,
  output fifoState_t        txState,
  output fifoState_t        rxState
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int SUM_W = CNT_FW + 1;

  logic [1:0]        pushV, popV;
  logic [WORD_W-1:0] pushD [2];
  logic [CNT_FW-1:0] thrV  [2];
  logic [WORD_W-1:0] headD [2];

  assign pushV    = {rxPush, strobe.txWrite};
  assign popV     = {strobe.rxRead, txPop};
  assign pushD[0] = strobe.txData;
  assign pushD[1] = rxWord;
  assign thrV[0]  = txThr;
  assign thrV[1]  = rxThr;

  // index 0 = transmit, index 1 = receive
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam bit IS_TX = (d == 0);
    logic [CNT_W-1:0] cnt;
    fifoState_t       st;

    pcm_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushV[d]),
      .pushData (pushD[d]),
      .pop      (popV[d]),
      .headData (headD[d]),
      .count    (cnt)
    );

    always_comb begin
      st.cnt         = CNT_FW'(cnt);
      st.empty       = (cnt == '0);
      st.full        = (cnt == CNT_W'(DEPTH));
      st.almostEmpty = (st.cnt <= thrV[d]);
      st.almostFull  = (SUM_W'(st.cnt) + SUM_W'(thrV[d])) >= SUM_W'(DEPTH);
      st.ovf         = pushV[d] && st.full;
      st.starve      = popV[d] && st.empty;
      st.xfer        = IS_TX ? (popV[d] && !st.empty) : (pushV[d] && !st.full);
    end
  end

  assign txState = g_dir[0].st;
  assign rxState = g_dir[1].st;
  assign txWord  = headD[0];
  assign rxHead  = headD[1];
endmodule

// File: rtl/pcm_irq_ctrl.sv
module pcm_irq_ctrl
  import pcm_fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [WR_W-1:0]   regWrData,
  output logic [RD_W-1:0]   regRdData,
  input  fifoState_t        txState,
  input  fifoState_t        rxState,
  input  logic [WORD_W-1:0] rxHead,
  output dpStrobe_t         strobe,
  output logic [CNT_FW-1:0] txThr,
  output logic [CNT_FW-1:0] rxThr,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irqOut
);
  logic             txDmaEn, rxDmaEn;
  logic [EVT_W-1:0] irqMask;
  logic             irqGlobal;
  logic [EVT_W-1:0] statusReg;
  logic [EVT_W-1:0] evt;
  logic [EVT_W-1:0] clrMask;
  logic             pending;
  logic             clrHit;

  assign clrHit  = regWr && (regAddr == ADDR_IRQCLR);
  assign clrMask = clrHit ? regWrData[EVT_W-1:0] : '0;

  assign strobe.txWrite = regWr && (regAddr == ADDR_TXDATA) && regWrData[WORD_W];
  assign strobe.txData  = regWrData[WORD_W-1:0];
  assign strobe.rxRead  = regRd && (regAddr == ADDR_RXDATA);

  assign evt = {txState.xfer | rxState.xfer,
                txState.empty, txState.almostEmpty, txState.full, txState.almostFull,
                txState.starve, txState.ovf,
                rxState.empty, rxState.almostEmpty, rxState.full, rxState.almostFull,
                rxState.starve, rxState.ovf};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr     <= '0;
      rxThr     <= '0;
      txDmaEn   <= 1'b0;
      rxDmaEn   <= 1'b0;
      irqMask   <= '0;
      irqGlobal <= 1'b0;
      statusReg <= '0;
    end else begin
      if (regWr && (regAddr == ADDR_CTRL)) begin
        txThr   <= regWrData[18:13];
        rxThr   <= regWrData[12:7];
        txDmaEn <= regWrData[6];
        rxDmaEn <= regWrData[5];
      end
      if (regWr && (regAddr == ADDR_IRQEN)) begin
        irqMask   <= regWrData[EVT_W-1:0];
        irqGlobal <= regWrData[14];
      end
      statusReg <= (statusReg & ~clrMask) | evt;
    end
  end

  assign pending  = irqGlobal && |(statusReg & irqMask);
  assign irqOut   = pending;
  assign txDmaReq = txDmaEn && txState.almostEmpty && !txState.full;
  assign rxDmaReq = rxDmaEn && rxState.almostFull && !rxState.empty;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdData = {1'b0, txThr, rxThr, txDmaEn, rxDmaEn, 5'b0};
      ADDR_IRQEN:  regRdData = {5'b0, irqGlobal, 1'b0, irqMask};
      ADDR_IRQST:  regRdData = {6'b0, pending, statusReg};
      ADDR_FSTAT:  regRdData = {txState.cnt, txState.empty, txState.almostEmpty,
                                txState.full, txState.almostFull,
                                rxState.cnt, rxState.empty, rxState.almostEmpty,
                                rxState.full, rxState.almostFull};
      ADDR_RXDATA: regRdData = rxState.empty ? '0 : {3'b0, 1'b1, rxHead};
      default:     regRdData = '0;
    endcase
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrHit |=> ((statusReg & $past(statusReg)) == $past(statusReg))); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> ((statusReg & $past(regWrData[EVT_W-1:0] & ~evt)) == '0)); // R10
  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxRead && rxState.empty) |-> (regRdData == '0)); // R4
endmodule

// File: rtl/pcm_fifo_irq_unit.sv
module pcm_fifo_irq_unit
  import pcm_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [WR_W-1:0]   regWrData,
  output logic [RD_W-1:0]   regRdData,
  input  logic              txPop,
  output logic [WORD_W-1:0] txWord,
  output logic              txWordValid,
  input  logic              rxPush,
  input  logic [WORD_W-1:0] rxWord,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  fifoState_t        txState, rxState;
  logic [CNT_FW-1:0] txThr, rxThr;
  logic [WORD_W-1:0] rxHead;

  pcm_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regRd     (regRd),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txState   (txState),
    .rxState   (rxState),
    .rxHead    (rxHead),
    .strobe    (strobe),
    .txThr     (txThr),
    .rxThr     (rxThr),
    .txDmaReq  (txDmaReq),
    .rxDmaReq  (rxDmaReq),
    .irqOut    (irqOut)
  );

  pcm_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .txThr   (txThr),
    .rxThr   (rxThr),
    .txPop   (txPop),
    .rxPush  (rxPush),
    .rxWord  (rxWord),
    .txWord  (txWord),
    .rxHead  (rxHead),
    .txState (txState),
    .rxState (rxState)
  );

  assign txWordValid = !txState.empty;

  AST_TX_REQ_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> !txState.full); // R7
  AST_RX_REQ_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> !rxState.empty); // R7
endmodule

// File: tb/pcm_fifo_irq_unit_bench.sv
module pcm_fifo_irq_unit_bench;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [18:0] regWrData = '0;
  logic [19:0] regRdData;
  logic        txPop = 1'b0;
  logic [15:0] txWord;
  logic        txWordValid;
  logic        rxPush = 1'b0;
  logic [15:0] rxWord = '0;
  logic        txDmaReq, rxDmaReq, irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  int txThrB = 0, rxThrB = 0;
  logic [15:0] txQ[$];
  logic [15:0] rxQ[$];

  always #4 clk = ~clk;

  pcm_fifo_irq_unit #(.DEPTH(DEPTH)) u_pcm_fifo_irq_unit (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txPop(txPop), .txWord(txWord),
    .txWordValid(txWordValid), .rxPush(rxPush), .rxWord(rxWord),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // expected FIFO status word from the R5/R6 formulas
  function automatic logic [31:0] fstat(int tc, int rc, int tt, int rt);
    logic [31:0] w;
    w = 32'(tc) << 14;
    w[13] = (tc == 0); w[12] = (tc <= tt); w[11] = (tc == DEPTH); w[10] = (tc + tt >= DEPTH);
    w = w | (32'(rc) << 4);
    w[3] = (rc == 0); w[2] = (rc <= rt); w[1] = (rc == DEPTH); w[0] = (rc + rt >= DEPTH);
    return w;
  endfunction

  // level status bits (R10 positions) for the current queue sizes
  function automatic logic [31:0] lvl(int tc, int rc, int tt, int rt);
    logic [31:0] w = '0;
    w[11] = (tc == 0); w[10] = (tc <= tt); w[9] = (tc == DEPTH); w[8] = (tc + tt >= DEPTH);
    w[5] = (rc == 0); w[4] = (rc <= rt); w[3] = (rc == DEPTH); w[2] = (rc + rt >= DEPTH);
    return w;
  endfunction

  function automatic logic [18:0] ctrlWord(int tt, int rt, bit te, bit re);
    return (19'(tt) << 13) | (19'(rt) << 7) | (19'(te) << 6) | (19'(re) << 5);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [18:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    #1 d = 32'(regRdData);
    @(negedge clk); regRd = 1'b0;
  endtask

  // scoreboard drivers: push expected words, drop beyond DEPTH (R8)
  task automatic txSend(input logic [15:0] w);
    if (txQ.size() < DEPTH) txQ.push_back(w);
    wr(3'd5, {3'b001, w});
  endtask

  task automatic rxSend(input logic [15:0] w);
    @(negedge clk); rxPush = 1'b1; rxWord = w;
    if (rxQ.size() < DEPTH) rxQ.push_back(w);
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic txTake();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic rxTake();
    logic [31:0] d;
    rd(3'd6, d);
  endtask

  // monitor: compares serializer-side and host-side words against the queues
  always begin
    @(negedge clk);
    #2;
    if (txPop) begin
      if (txQ.size() > 0) begin
        chk("R3 txWordValid", 32'(txWordValid), 32'd1);
        chk("R3 tx word order", 32'(txWord), 32'(txQ.pop_front()));
      end else begin
        chk("R3 txWordValid when empty", 32'(txWordValid), 32'd0);
      end
    end
    if (regRd && regAddr == 3'd6) begin
      if (rxQ.size() > 0) chk("R4 rx word", 32'(regRdData), {15'b0, 1'b1, rxQ.pop_front()});
      else                chk("R4 rx empty read", 32'(regRdData), 32'd0);
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 / R5 reset state
    #1;
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 txDmaReq", 32'(txDmaReq), 0);
    chk("R1 rxDmaReq", 32'(rxDmaReq), 0);
    rd(3'd4, d); chk("R5 reset fifo status", d, 32'h300C);
    rd(3'd0, d); chk("R1 control reset", d, 0);
    rd(3'd1, d); chk("R1 irq enable reset", d, 0);

    // R6 control fields, thresholds 4 / 32
    txThrB = 4; rxThrB = 32;
    wr(3'd0, ctrlWord(4, 32, 1, 1));
    rd(3'd0, d); chk("R6 control readback", d, 32'h9060);
    rd(3'd4, d); chk("R6 fifo status thr 4/32", d, 32'h300D);
    #1;
    chk("R7 txDmaReq empty", 32'(txDmaReq), 1);
    chk("R7 rxDmaReq empty", 32'(rxDmaReq), 0);

    // R2 write without valid flag ignored
    wr(3'd5, 19'h0ABCD);
    rd(3'd4, d); chk("R2 no-valid write ignored", d, fstat(0, 0, 4, 32));

    // R3 transmit path
    for (int i = 0; i < 6; i++) txSend(16'h1000 + 16'(i * 37));
    rd(3'd4, d); chk("R5 tx count 6", d, fstat(6, 0, 4, 32));
    #1 chk("R7 txDmaReq above thr", 32'(txDmaReq), 0);
    for (int i = 0; i < 6; i++) txTake();
    #1 chk("R3 tx drained", 32'(txWordValid), 0);

    // R4 receive path
    for (int i = 0; i < 3; i++) rxSend(16'hC000 ^ 16'(i * 91));
    #1 chk("R7 rxDmaReq thr 32 nonempty", 32'(rxDmaReq), 1);
    for (int i = 0; i < 4; i++) rxTake();
    rd(3'd2, d); chk("R9 rx starve bit", d & 32'h2, 32'h2);

    // R10 clear all: only level bits remain
    wr(3'd3, 19'h1FFF);
    rd(3'd2, d); chk("R10 clear leaves level bits", d, lvl(0, 0, 4, 32));

    // R9 tx starvation, R11 global gate
    wr(3'd1, 19'h00080);
    txTake();
    rd(3'd2, d); chk("R9 tx starve bit", d & 32'h80, 32'h80);
    #1 chk("R11 irq gated by global", 32'(irqOut), 0);
    wr(3'd1, 19'h04080);
    #1 chk("R11 irq asserted", 32'(irqOut), 1);
    rd(3'd2, d); chk("R11 pending bit", d & 32'h2000, 32'h2000);
    wr(3'd3, 19'h00080);
    #1 chk("R11 irq after clear", 32'(irqOut), 0);
    rd(3'd2, d); chk("R10 cleared to level", d, lvl(0, 0, 4, 32));

    // R12 word transfer
    wr(3'd1, 19'h05000);
    rxSend(16'h5A5A);
    #1 chk("R12 irq on word transfer", 32'(irqOut), 1);
    rd(3'd2, d); chk("R12 xfer bit", d & 32'h1000, 32'h1000);
    rxTake();
    wr(3'd3, 19'h01000);
    #1 chk("R12 irq cleared", 32'(irqOut), 0);
    wr(3'd1, 19'h0);

    // R8 tx overflow
    for (int i = 0; i < DEPTH; i++) txSend(16'h2000 + 16'(i));
    rd(3'd4, d); chk("R5 tx full status", d, fstat(DEPTH, 0, 4, 32));
    #1 chk("R7 txDmaReq full", 32'(txDmaReq), 0);
    rd(3'd2, d); chk("R8 no tx ovf yet", d & 32'h40, 0);
    txSend(16'hDEAD);
    rd(3'd2, d); chk("R8 tx ovf bit", d & 32'h40, 32'h40);
    rd(3'd4, d); chk("R8 tx count stays", d, fstat(DEPTH, 0, 4, 32));
    for (int i = 0; i < DEPTH; i++) txTake();

    // R8 rx overflow
    for (int i = 0; i < DEPTH + 1; i++) rxSend(16'h7700 + 16'(i));
    rd(3'd2, d); chk("R8 rx ovf bit", d & 32'h1, 32'h1);
    rd(3'd4, d); chk("R8 rx count stays", d, fstat(0, DEPTH, 4, 32));
    for (int i = 0; i < DEPTH; i++) rxTake();

    // R6 / R7 threshold boundaries 3 / 2
    txThrB = 3; rxThrB = 2;
    wr(3'd0, ctrlWord(3, 2, 1, 1));
    for (int i = 0; i < 3; i++) txSend(16'h3300 + 16'(i));
    rd(3'd4, d); chk("R6 tx almost-empty at thr", d, fstat(3, 0, 3, 2));
    #1 chk("R7 txDmaReq at thr", 32'(txDmaReq), 1);
    txSend(16'h33FF);
    #1 chk("R7 txDmaReq above thr", 32'(txDmaReq), 0);
    for (int i = 0; i < 29; i++) rxSend(16'h4400 + 16'(i));
    rd(3'd4, d); chk("R6 rx below almost-full", d, fstat(4, 29, 3, 2));
    #1 chk("R7 rxDmaReq below", 32'(rxDmaReq), 0);
    rxSend(16'h44FF);
    rd(3'd4, d); chk("R6 rx at almost-full", d, fstat(4, 30, 3, 2));
    #1 chk("R7 rxDmaReq at boundary", 32'(rxDmaReq), 1);
    for (int i = 0; i < 4; i++) txTake();
    for (int i = 0; i < 30; i++) rxTake();
    rd(3'd4, d); chk("R5 both drained", d, fstat(0, 0, 3, 2));

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule